// File: doc/BRIEF.md
# Power-State-Dependent Wake Event Generator

This block raises a wake request on a shared, active-low, open-drain wake pin on behalf of several logical functions. Each function reports its current power state (D0, D2 or D3) on a two-bit input. The function's serial channels supply modem-control lines and serial data inputs. Which line activity counts as a wake event depends on that power state. In D0 nothing wakes. In D2 a level change on any unmasked modem line or serial input wakes. In D3 only the trailing (falling) edge of a channel's ring-indicate line wakes.

A wake event sets a sticky per-function status bit immediately, with no filter delay. Software clears the bit with a write-one-to-clear strobe. The shared pin is pulled low while any function has its status set and its wake-enable bit set. The pin is released to high impedance only when no enabled function still holds status.

Each function runs a small state machine with these states:
- ST_IDLE: D0 or the unused code, so no wake sources are watched.
- ST_WATCH2: D2 watching.
- ST_WATCH3: D3 watching.
- ST_PENDING: status held.

The transitions are:
- watch-follow: among the three non-pending states, the state follows the power input.
- wake: any non-pending state moves to ST_PENDING on a qualified event.
- hold: ST_PENDING stays put while no clear arrives, or while a clear and an event fall in the same cycle.
- release: a clear with no event leaves ST_PENDING for the state that matches the power input.

Top module: `pme_wake_gen`

## Requirements
- R1: After reset every status bit is 0, the pin drive enable is 0, and all wake mask bits are 0, so every source is enabled.
- R2: With power code 2'b00 (D0) or 2'b01 (unused, treated as D0), no line activity sets status.
- R3: With power code 2'b10 (D2), a rise or a fall on an unmasked source sets that function's status.
- R4: A pulse on mask_we_i[f] loads mask_wdata_i into function f's mask. Within channel c, bit c*5+m masks modem line m and bit c*5+4 masks the serial input. A 1 disables the source, and a masked source never sets status.
- R5: With power code 2'b11 (D3), only a falling edge of a ring-indicate line sets status. Rises of ring-indicate and all changes on other lines do nothing, and masks do not apply. The modem bit order within a channel is 0 = CTS, 1 = DSR, 2 = RI, 3 = DCD.
- R6: Status is sticky. It persists through later power-state changes and line activity until the function's clear strobe arrives.
- R7: sts_clr_i[f] with no coincident event clears status at that edge. It affects only function f.
- R8: If a clear strobe and a qualified wake event fall in the same cycle, status stays set.
- R9: pme_oe_o is 1 exactly when some function has status set and its pme_en_i bit set. pme_n_o is 0 while pme_oe_o is 1 and high impedance otherwise.
- R10: Status rises on the third rising clock edge after the line changes, and is still 0 after the second edge. No filter time is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_state_i | input | 2*NUM_FUNC | Power code per function (00 D0, 01 unused, 10 D2, 11 D3) |
| pme_en_i | input | NUM_FUNC | Wake pin enable per function |
| sts_clr_i | input | NUM_FUNC | Write-one-to-clear strobe for status |
| mask_we_i | input | NUM_FUNC | Mask write strobe per function |
| mask_wdata_i | input | NUM_CH*5 | Mask write data |
| modem_i | input | NUM_FUNC*NUM_CH*4 | Modem lines, index (f*NUM_CH+c)*4+m |
| sin_i | input | NUM_FUNC*NUM_CH | Serial data inputs, index f*NUM_CH+c |
| pme_sts_o | output | NUM_FUNC | Sticky wake status per function |
| pme_oe_o | output | 1 | Pin drive enable |
| pme_n_o | output | 1 | Active-low open-drain wake pin |

## Verification
A software clear strobe and a newly qualified wake event can land in the same cycle. The bench provokes this by setting a function's status, toggling a second unmasked line in D2, and raising the clear strobe exactly in the cycle before the third edge after the toggle. It expects status to remain set and the pin to stay low. A clear issued one cycle later must then drop the status. The sweeps cover every function, power code, source, edge direction and three mask patterns, and the bench computes the expected status from those inputs alone.

// File: rtl/pme_wake_pkg.sv
package pme_wake_pkg;

    typedef enum logic [1:0] {
        PS_D0 = 2'b00,
        PS_D1 = 2'b01,
        PS_D2 = 2'b10,
        PS_D3 = 2'b11
    } pwr_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WATCH2,
        ST_WATCH3,
        ST_PENDING
    } wst_e;

    localparam int MODEM_W    = 4;
    localparam int RI_BIT     = 2;
    localparam int SRC_PER_CH = MODEM_W + 1;

endpackage

// File: rtl/pme_line_sync.sv
module pme_line_sync #(
    parameter int W = 10
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] lines_i,
    output logic [W-1:0] chg_o,
    output logic [W-1:0] fall_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    // two stages of synchronisation, then one history stage for edges
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= lines_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    always_comb begin
        chg_o  = sync_q ^ prev_q;
        fall_o = prev_q & ~sync_q;
    end

endmodule

// File: rtl/pme_src_qual.sv
module pme_src_qual
    import pme_wake_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int SRC_W = NUM_CH * SRC_PER_CH
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [1:0]       pwr_i,
    input  logic [SRC_W-1:0] chg_i,
    input  logic [SRC_W-1:0] fall_i,
    input  logic [SRC_W-1:0] mask_i,
    output logic             ev_o
);

    function automatic logic [SRC_W-1:0] ri_select();
        logic [SRC_W-1:0] v;
        v = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            v[c*SRC_PER_CH + RI_BIT] = 1'b1;
        end
        return v;
    endfunction

    localparam logic [SRC_W-1:0] RI_SEL = ri_select();

    logic d2_hit;
    logic d3_hit;

    always_comb begin
        d2_hit = |(chg_i & ~mask_i);
        d3_hit = |(fall_i & RI_SEL);
        unique case (pwr_e'(pwr_i))
            PS_D2:   ev_o = d2_hit;
            PS_D3:   ev_o = d3_hit;
            default: ev_o = 1'b0;
        endcase
    end

    // R5
    d3_ri_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pwr_i == PS_D3 && ev_o) |-> (|(fall_i & RI_SEL)));

    // R2
    d0_no_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pwr_i == PS_D0 || pwr_i == PS_D1) |-> !ev_o);

endmodule

// File: rtl/pme_fn_ctrl.sv
module pme_fn_ctrl
    import pme_wake_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int SRC_W = NUM_CH * SRC_PER_CH
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [1:0]       pwr_i,
    input  logic             ev_i,
    input  logic             clr_i,
    input  logic             mask_we_i,
    input  logic [SRC_W-1:0] mask_wdata_i,
    output logic [SRC_W-1:0] mask_o,
    output logic             sts_o
);

    wst_e state_q;
    wst_e state_d;
    wst_e watch_st;
    logic [SRC_W-1:0] mask_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mask_q <= '0;
        end else if (mask_we_i) begin
            mask_q <= mask_wdata_i;
        end
    end

    always_comb begin
        unique case (pwr_e'(pwr_i))
            PS_D2:   watch_st = ST_WATCH2;
            PS_D3:   watch_st = ST_WATCH3;
            default: watch_st = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_PENDING: state_d = (clr_i && !ev_i) ? watch_st : ST_PENDING;
            ST_IDLE,
            ST_WATCH2,
            ST_WATCH3:  state_d = ev_i ? ST_PENDING : watch_st;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        sts_o  = (state_q == ST_PENDING);
        mask_o = mask_q;
    end

    // R6
    sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sts_o && !clr_i) |=> sts_o);

    // R8
    clr_collide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sts_o && clr_i && ev_i) |=> sts_o);

    // R7
    clr_effect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sts_o && clr_i && !ev_i) |=> !sts_o);

    // R2
    d0_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sts_o && (pwr_i == PS_D0 || pwr_i == PS_D1)) |=> !sts_o);

    // R4
    mask_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mask_we_i |=> (mask_o == $past(mask_wdata_i)));

endmodule

// File: rtl/pme_pin_share.sv
module pme_pin_share #(
    parameter int NUM_FUNC = 2
) (
    input  logic [NUM_FUNC-1:0] sts_i,
    input  logic [NUM_FUNC-1:0] en_i,
    output logic                oe_o,
    output logic                pin_n_o
);

    always_comb begin
        oe_o = |(sts_i & en_i);
    end

    assign pin_n_o = oe_o ? 1'b0 : 1'bz;

endmodule

// File: rtl/pme_wake_gen.sv
module pme_wake_gen
    import pme_wake_pkg::*;
#(
    parameter int NUM_FUNC = 2,
    parameter int NUM_CH   = 2,
    localparam int SRC_W   = NUM_CH * SRC_PER_CH
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic [2*NUM_FUNC-1:0]          pwr_state_i,
    input  logic [NUM_FUNC-1:0]            pme_en_i,
    input  logic [NUM_FUNC-1:0]            sts_clr_i,
    input  logic [NUM_FUNC-1:0]            mask_we_i,
    input  logic [SRC_W-1:0]               mask_wdata_i,
    input  logic [NUM_FUNC*NUM_CH*4-1:0]   modem_i,
    input  logic [NUM_FUNC*NUM_CH-1:0]     sin_i,
    output logic [NUM_FUNC-1:0]            pme_sts_o,
    output logic                           pme_oe_o,
    output logic                           pme_n_o
);

    for (genvar f = 0; f < NUM_FUNC; f++) begin : g_fn
        logic [SRC_W-1:0] lines;
        logic [SRC_W-1:0] chg;
        logic [SRC_W-1:0] fall;
        logic [SRC_W-1:0] mask;
        logic             ev;

        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            assign lines[c*SRC_PER_CH +: MODEM_W] = modem_i[(f*NUM_CH + c)*MODEM_W +: MODEM_W];
            assign lines[c*SRC_PER_CH + MODEM_W]  = sin_i[f*NUM_CH + c];
        end

        pme_line_sync #(.W(SRC_W)) u_sync (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .lines_i (lines),
            .chg_o   (chg),
            .fall_o  (fall)
        );

        pme_src_qual #(.NUM_CH(NUM_CH)) u_qual (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .pwr_i  (pwr_state_i[2*f +: 2]),
            .chg_i  (chg),
            .fall_i (fall),
            .mask_i (mask),
            .ev_o   (ev)
        );

        pme_fn_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
            .clk_i        (clk_i),
            .rst_ni       (rst_ni),
            .pwr_i        (pwr_state_i[2*f +: 2]),
            .ev_i         (ev),
            .clr_i        (sts_clr_i[f]),
            .mask_we_i    (mask_we_i[f]),
            .mask_wdata_i (mask_wdata_i),
            .mask_o       (mask),
            .sts_o        (pme_sts_o[f])
        );
    end

    pme_pin_share #(.NUM_FUNC(NUM_FUNC)) u_pin (
        .sts_i   (pme_sts_o),
        .en_i    (pme_en_i),
        .oe_o    (pme_oe_o),
        .pin_n_o (pme_n_o)
    );

endmodule

// File: tb/pme_wake_gen_tb.sv
module pme_wake_gen_tb_top;

    localparam int CLK_P = 10;
    localparam int NF    = 2;
    localparam int NC    = 2;
    localparam int SW    = NC * 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2*NF-1:0]   pwr = '0;
    logic [NF-1:0]     en = '0;
    logic [NF-1:0]     clr = '0;
    logic [NF-1:0]     mwe = '0;
    logic [SW-1:0]     mwd = '0;
    logic [NF*NC*4-1:0] modem;
    logic [NF*NC-1:0]  sin;
    logic [NF-1:0]     sts;
    logic              oe;
    logic              pin_n;

    logic [SW-1:0] lvl [NF];
    logic [SW-1:0] msk [NF];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    pme_wake_gen #(.NUM_FUNC(NF), .NUM_CH(NC)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .pwr_state_i(pwr), .pme_en_i(en),
        .sts_clr_i(clr), .mask_we_i(mwe), .mask_wdata_i(mwd),
        .modem_i(modem), .sin_i(sin), .pme_sts_o(sts), .pme_oe_o(oe), .pme_n_o(pin_n)
    );

    always_comb begin
        for (int f = 0; f < NF; f++)
            for (int c = 0; c < NC; c++) begin
                modem[(f*NC+c)*4 +: 4] = lvl[f][c*5 +: 4];
                sin[f*NC+c]            = lvl[f][c*5+4];
            end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_fn(input int f);
        clr[f] = 1'b1;
        tick(1);
        clr[f] = 1'b0;
    endtask

    task automatic write_mask(input int f, input logic [SW-1:0] m);
        mwd = m; mwe[f] = 1'b1;
        tick(1);
        mwe[f] = 1'b0;
        msk[f] = m;
    endtask

    task automatic set_pwr(input int f, input logic [1:0] p);
        pwr[2*f +: 2] = p;
    endtask

    // one toggle of one source under one power code
    task automatic trial(input int f, input logic [1:0] p, input int src, input logic [NF-1:0] e);
        bit falling, exp;
        string tag;
        set_pwr(f, p);
        en = e;
        tick(3);
        falling = lvl[f][src];
        if (p == 2'b10)      exp = !msk[f][src];
        else if (p == 2'b11) exp = falling && (src % 5 == 2);
        else                 exp = 0;
        if (p == 2'b10)      tag = msk[f][src] ? "R4" : "R3";
        else if (p == 2'b11) tag = "R5";
        else                 tag = "R2";
        lvl[f][src] = ~lvl[f][src];
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R10 latency", int'(sts[f]), 0);
        tick(1);
        chk(tag, int'(sts[f]), int'(exp));
        chk("R7 other function", int'(sts[1-f]), 0);
        chk("R9 drive", int'(oe), int'(exp && e[f]));
        if (exp && e[f]) chk("R9 pin low", int'(pin_n === 1'b0), 1);
        set_pwr(f, 2'b00);
        tick(2);
        clear_fn(f);
        chk("R7 clear", int'(sts[f]), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int f = 0; f < NF; f++) begin lvl[f] = '0; msk[f] = '0; end
        tick(3);
        rst_n = 1'b1;
        tick(2);
        // R1 reset state
        chk("R1 status", int'(sts), 0);
        chk("R1 drive", int'(oe), 0);

        // phase A: masks at reset value (R1: all sources enabled)
        for (int ph = 0; ph < 3; ph++) begin
            for (int f = 0; f < NF; f++) begin
                if (ph == 1) write_mask(f, '1);
                if (ph == 2) write_mask(f, SW'(10'h155));
                for (int p = 0; p < 4; p++)
                    for (int s = 0; s < SW; s++)
                        for (int d = 0; d < 2; d++)
                            trial(f, 2'(p), s, NF'(s + d + p));
            end
        end
        for (int f = 0; f < NF; f++) write_mask(f, '0);

        // R6 sticky across power changes and line activity, R9 enable gating
        en = '0;
        set_pwr(1, 2'b11);
        lvl[1][2] = 1'b1; tick(5);
        chk("R5 ri rise", int'(sts[1]), 0);
        lvl[1][2] = 1'b0; tick(4);
        chk("R5 ri fall", int'(sts[1]), 1);
        chk("R9 disabled", int'(oe), 0);
        set_pwr(1, 2'b00); tick(3);
        set_pwr(1, 2'b10); lvl[1][0] = ~lvl[1][0]; tick(5);
        set_pwr(1, 2'b00); tick(3);
        chk("R6 sticky", int'(sts[1]), 1);
        en = 2'b10; tick(1);
        chk("R9 enabled", int'(oe), 1);
        chk("R9 pin", int'(pin_n === 1'b0), 1);

        // shared pin: both functions pending
        en = 2'b11;
        set_pwr(0, 2'b10);
        lvl[0][4] = ~lvl[0][4]; tick(4);
        chk("R3 sin", int'(sts[0]), 1);
        clear_fn(0);
        chk("R7 own only", int'(sts), 2);
        chk("R9 shared held", int'(oe), 1);
        clear_fn(1);
        chk("R9 shared release", int'(oe), 0);

        // R8 clear colliding with a wake event (function 0 still in D2)
        lvl[0][1] = ~lvl[0][1]; tick(4);
        chk("R3 preset", int'(sts[0]), 1);
        lvl[0][3] = ~lvl[0][3];
        repeat (2) @(posedge clk);
        @(negedge clk);
        clr[0] = 1'b1;
        tick(1);
        clr[0] = 1'b0;
        chk("R8 collide", int'(sts[0]), 1);
        chk("R8 pin", int'(oe), 1);
        clear_fn(0);
        chk("R7 after collide", int'(sts[0]), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule